// File: doc/BRIEF.md
# Ping-Pong Integration Conversion Sequencer

This block sits on the host side of a dual-integrator current-to-digital front end and produces its convert strobe. The front end has two integrators, A and B, for each input. A rising strobe edge makes side A integrate. A falling edge moves integration to side B and sends side A's charge to conversion. Each integration therefore lasts from one strobe edge to the next. The sequencer times every integration in system clocks. It keeps each integration at or above the front end's minimum length. After a request that is too short, it runs a recovery schedule. It also opens a readout window that keeps the serial readout clock away from strobe edges.

The host sets the requested integration length in internal clocks and a divide-by-four setting, then pulses `start`. From then on the sequencer runs with no further commands. A new length or divide setting takes effect at the next integration boundary. A request shorter than the minimum is clamped to the minimum and flagged. The three integrations that follow are then stretched to a long recovery length. The data-usable flag stays low during warm-up and recovery, and otherwise goes high. Every output is registered on the falling system-clock edge, so strobe transitions line up with that edge.

Top module: `pingpong_int_seq`

## Requirements
- R1: While `rst_n` is low at the clock edges, `cvt_strobe`, `side_b`, `rd_win`, `usable` and `short_int` are all 0. After release the sequencer stays idle, with `cvt_strobe` low, until `start` is seen high.
- R2: A `start` seen while idle raises `cvt_strobe`. From then on the strobe alternates forever. Each level is held for P = max(`int_len`, MIN_INT) × D system clocks, where D is 1 when `clk_div4` = 0 and 4 when `clk_div4` = 1.
- R3: After start, `side_b` is 0 while `cvt_strobe` is high (side A integrating) and 1 while it is low. While idle, `side_b` is 0.
- R4: `usable` changes only at a strobe edge that ends an integration. It is 0 after each of the first four such edges following start. It is 1 at later edges whose ending integration was neither clamped nor part of recovery.
- R5: Count output cycles j = 0 … P−1 from each strobe edge of an integration of length P. `rd_win` is 1 exactly when GUARD ≤ j ≤ P−1−GUARD, and it is 0 while idle.
- R6: `int_len` and `clk_div4` are sampled only when an integration begins. A change during an integration sets the length of the next one. `clk_div4` = 1 multiplies the length in system clocks by 4.
- R7: An `int_len` below MIN_INT makes that integration last MIN_INT × D clocks. `short_int` is 1 for exactly that integration.
- R8: The three integrations after a clamped one last max(`int_len`, REC_INT) × D clocks and are never flagged as clamped. `usable` is 0 at the end of the clamped integration and at the end of each recovery integration. Normal lengths resume afterwards.
- R9: Pulling `rst_n` low in the middle of a run returns the sequencer to idle with the strobe low. A new `start` is needed to run again.
- R10: All outputs change only on the falling edge of `clk`.
- R11: `start` seen while running has no effect on the timing of the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin sequencing when idle |
| int_len | input | LEN_W | Requested integration length in internal clocks |
| clk_div4 | input | 1 | 1: internal clock is system clock / 4 |
| cvt_strobe | output | 1 | Convert strobe level to the front end |
| side_b | output | 1 | 1 while side B integrates |
| rd_win | output | 1 | Readout clock may run |
| usable | output | 1 | Result of the last finished integration may be used |
| short_int | output | 1 | Current integration was clamped to the minimum |

## Verification
The sequencer is run with a long request and no divide, with the same request under divide-by-four, and with a request changed in the middle of an integration. These cases separate a cycle count that scales correctly from one that does not, and sampling at the integration boundary from sampling at any time. Two short requests follow. One is followed by a request below the recovery length and the other by a request above it. Together they show whether the clamp, the count of three recovery integrations and the max rule during recovery are each applied. The warm-up count, the exact window boundaries, falling-edge-only output changes, a start pulse held during a run and a reset in the middle of a run are each checked in a directed scenario of their own.

// File: rtl/pis_pkg.sv
package pis_pkg;

  typedef struct packed {
    logic strobe;
    logic side_b;
    logic rd_win;
    logic usable;
    logic short_int;
  } seq_out_t;

  // Length raised to a floor, both in internal clocks.
  function automatic int unsigned floor_ticks(int unsigned req, int unsigned floor_t);
    return (req < floor_t) ? floor_t : req;
  endfunction

  // Internal clocks to system clocks for the chosen divide setting.
  function automatic int unsigned ticks_to_cycles(int unsigned ticks, logic div4);
    return div4 ? (ticks << 2) : ticks;
  endfunction

endpackage

// File: rtl/pis_period_sel.sv
module pis_period_sel #(
  parameter int LEN_W    = 16,
  parameter int CNT_W    = 18,
  parameter int MIN_INT  = 1600,
  parameter int REC_INT  = 5000,
  parameter int REC_RUNS = 3,
  localparam int REC_W   = $clog2(REC_RUNS + 1)
) (
  input  logic [LEN_W-1:0] req_len,
  input  logic             div4,
  input  logic [REC_W-1:0] rec_left,
  output logic [CNT_W-1:0] period,
  output logic             is_short,
  output logic             is_rec,
  output logic [REC_W-1:0] rec_next
);
  import pis_pkg::*;

  int unsigned req_u;
  int unsigned ticks;

  always_comb begin
    req_u    = 32'(req_len);
    is_rec   = (rec_left != '0);
    is_short = !is_rec && (req_u < MIN_INT);
    if (is_rec) ticks = floor_ticks(req_u, REC_INT);
    else        ticks = floor_ticks(req_u, MIN_INT);
    period   = CNT_W'(ticks_to_cycles(ticks, div4));
    if (is_rec)        rec_next = rec_left - 1'b1;
    else if (is_short) rec_next = REC_W'(REC_RUNS);
    else               rec_next = '0;
  end

endmodule

// File: rtl/pis_guard.sv
module pis_guard #(
  parameter int CNT_W     = 18,
  parameter int GUARD_CYC = 400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running,
  input  logic             new_int,
  input  logic [CNT_W-1:0] remain,
  output logic [CNT_W-1:0] since_o,
  output logic             win
);
  logic [CNT_W-1:0] since;

  always_ff @(posedge clk) begin
    if (!rst_n)             since <= '0;
    else if (new_int)       since <= '0;
    else if (since != '1)   since <= since + 1'b1;
  end

  assign since_o = since;
  assign win = running && (since >= CNT_W'(GUARD_CYC)) && (remain > CNT_W'(GUARD_CYC));

  // R5
  win_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win) |-> (since == CNT_W'(GUARD_CYC)));

  // R5
  win_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    new_int |-> !win);

endmodule

// File: rtl/pis_quality.sv
module pis_quality #(
  parameter int WARMUP = 4,
  localparam int EW    = $clog2(WARMUP + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic toggle,
  input  logic cur_short,
  input  logic cur_rec,
  output logic ok_q
);
  logic [EW-1:0] ends;

  always_ff @(posedge clk) begin
    if (!rst_n || launch) begin
      ends <= '0;
      ok_q <= 1'b0;
    end else if (toggle) begin
      ok_q <= (ends >= EW'(WARMUP)) && !cur_short && !cur_rec;
      if (ends < EW'(WARMUP)) ends <= ends + 1'b1;
    end
  end

  // R4
  warmup_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_q) |-> (ends == EW'(WARMUP)));

  // R8
  rec_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (toggle && (cur_rec || cur_short)) |=> !ok_q);

endmodule

// File: rtl/pis_out_align.sv
module pis_out_align (
  input  logic              clk,
  input  logic              rst_n,
  input  pis_pkg::seq_out_t d,
  output pis_pkg::seq_out_t q
);
  always_ff @(negedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/pingpong_int_seq.sv
module pingpong_int_seq #(
  parameter int LEN_W     = 16,
  parameter int MIN_INT   = 1600,
  parameter int REC_INT   = 5000,
  parameter int REC_RUNS  = 3,
  parameter int WARMUP    = 4,
  parameter int GUARD_CYC = 400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] int_len,
  input  logic             clk_div4,
  output logic             cvt_strobe,
  output logic             side_b,
  output logic             rd_win,
  output logic             usable,
  output logic             short_int
);
  import pis_pkg::*;

  localparam int CNT_W = LEN_W + 2;
  localparam int REC_W = $clog2(REC_RUNS + 1);

  logic             running;
  logic             strobe_req;
  logic [CNT_W-1:0] remain;
  logic             cur_short;
  logic             cur_rec;
  logic [REC_W-1:0] rec_left;

  logic [CNT_W-1:0] nxt_period;
  logic             nxt_short;
  logic             nxt_rec;
  logic [REC_W-1:0] nxt_rec_left;
  logic [CNT_W-1:0] since;
  logic             win;
  logic             ok_q;

  wire launch  = !running && start;
  wire toggle  = running && (remain == CNT_W'(1));
  wire new_int = launch || toggle;

  pis_period_sel #(
    .LEN_W(LEN_W), .CNT_W(CNT_W), .MIN_INT(MIN_INT),
    .REC_INT(REC_INT), .REC_RUNS(REC_RUNS)
  ) u_sel (
    .req_len(int_len), .div4(clk_div4), .rec_left(rec_left),
    .period(nxt_period), .is_short(nxt_short), .is_rec(nxt_rec),
    .rec_next(nxt_rec_left)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running    <= 1'b0;
      strobe_req <= 1'b0;
      remain     <= '0;
      cur_short  <= 1'b0;
      cur_rec    <= 1'b0;
      rec_left   <= '0;
    end else begin
      if (launch) running <= 1'b1;
      if (new_int) begin
        strobe_req <= launch ? 1'b1 : ~strobe_req;
        remain     <= nxt_period;
        cur_short  <= nxt_short;
        cur_rec    <= nxt_rec;
        rec_left   <= nxt_rec_left;
      end else if (running) begin
        remain <= remain - 1'b1;
      end
    end
  end

  pis_guard #(.CNT_W(CNT_W), .GUARD_CYC(GUARD_CYC)) u_guard (
    .clk(clk), .rst_n(rst_n), .running(running), .new_int(new_int),
    .remain(remain), .since_o(since), .win(win)
  );

  pis_quality #(.WARMUP(WARMUP)) u_qual (
    .clk(clk), .rst_n(rst_n), .launch(launch), .toggle(toggle),
    .cur_short(cur_short), .cur_rec(cur_rec), .ok_q(ok_q)
  );

  seq_out_t out_d, out_q;

  always_comb begin
    out_d.strobe    = strobe_req;
    out_d.side_b    = running && !strobe_req;
    out_d.rd_win    = win;
    out_d.usable    = ok_q;
    out_d.short_int = running && cur_short;
  end

  pis_out_align u_align (.clk(clk), .rst_n(rst_n), .d(out_d), .q(out_q));

  assign cvt_strobe = out_q.strobe;
  assign side_b     = out_q.side_b;
  assign rd_win     = out_q.rd_win;
  assign usable     = out_q.usable;
  assign short_int  = out_q.short_int;

  // R2
  period_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    toggle |-> ((32'(since) + 1) >= MIN_INT));

  // R9
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !strobe_req);

  // R8
  rec_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rec_left) <= REC_RUNS);

  // R7
  short_rec_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cur_short && cur_rec));

endmodule

// File: tb/tb_pingpong_int_seq.sv
`timescale 1ns/1ps
module tb_pingpong_int_seq;
  localparam int LEN_W = 12;
  localparam int MINI  = 40;
  localparam int RECI  = 100;
  localparam int GRD   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] int_len = '0;
  logic clk_div4 = 1'b0;
  logic cvt, side_b, rd_win, usable, short_int;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  pingpong_int_seq #(
    .LEN_W(LEN_W), .MIN_INT(MINI), .REC_INT(RECI),
    .REC_RUNS(3), .WARMUP(4), .GUARD_CYC(GRD)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .int_len(int_len),
    .clk_div4(clk_div4), .cvt_strobe(cvt), .side_b(side_b),
    .rd_win(rd_win), .usable(usable), .short_int(short_int)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_edge();
    logic prev;
    int n;
    prev = cvt;
    n = 0;
    do begin step(); n++; end while (cvt == prev && n < 20000);
  endtask

  // From output cycle j=0 of an integration, count to the next edge.
  task automatic meas_here(output int p);
    logic prev;
    prev = cvt;
    p = 0;
    do begin step(); p++; end while (cvt == prev && p < 20000);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    start = 1'b0;
    repeat (4) step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic launch_run(input int len, input logic d4);
    int_len = LEN_W'(len);
    clk_div4 = d4;
    start = 1'b1;
    step();
    start = 1'b0;
    if (!cvt) wait_edge();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) step();
    chk({cvt, side_b, rd_win, usable, short_int} == 5'b0, "R1 outputs in reset",
        {cvt, side_b, rd_win, usable, short_int}, 0);
    rst_n = 1'b1;
    int_len = 12'd60;
    repeat (50) step();
    chk(cvt == 1'b0 && side_b == 1'b0, "R1 idle after release", cvt, 0);
  endtask

  task automatic t_normal();
    int p;
    do_reset();
    launch_run(60, 1'b0);
    chk(cvt == 1'b1 && side_b == 1'b0, "R3 side A while strobe high", side_b, 0);
    meas_here(p);
    chk(p == 60, "R2 high period", p, 60);
    chk(cvt == 1'b0 && side_b == 1'b1, "R3 side B while strobe low", side_b, 1);
    start = 1'b1;
    meas_here(p);
    start = 1'b0;
    chk(p == 60, "R11 start while running ignored", p, 60);
    int_len = 12'd80;
    meas_here(p);
    chk(p == 60, "R6 change mid-integration not applied", p, 60);
    meas_here(p);
    chk(p == 80, "R6 change applied at next integration", p, 80);
  endtask

  task automatic t_warmup();
    do_reset();
    launch_run(50, 1'b0);
    chk(usable == 1'b0, "R4 usable low at start", usable, 0);
    for (int n = 1; n <= 6; n++) begin
      wait_edge();
      chk(usable == (n >= 5), "R4 warmup end count", usable, (n >= 5));
    end
  endtask

  task automatic t_window();
    int bad;
    do_reset();
    launch_run(60, 1'b0);
    wait_edge();
    bad = 0;
    for (int j = 0; j < 60; j++) begin
      if (rd_win != ((j >= GRD) && (j <= 60 - 1 - GRD))) bad++;
      step();
    end
    chk(bad == 0, "R5 window bounds mismatches", bad, 0);
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    bad = 0;
    for (int j = 0; j < 30; j++) begin
      if (rd_win) bad++;
      step();
    end
    chk(bad == 0, "R5 window closed while idle", bad, 0);
  endtask

  task automatic t_short_recovery();
    int p;
    int okc;
    do_reset();
    launch_run(60, 1'b0);
    int_len = 12'd10;
    meas_here(p);
    chk(short_int == 1'b1, "R7 clamped flag set", short_int, 1);
    int_len = 12'd60;
    meas_here(p);
    chk(p == MINI, "R7 clamped length", p, MINI);
    chk(short_int == 1'b0 && usable == 1'b0, "R8 end of clamped not usable",
        {short_int, usable}, 0);
    okc = 0;
    for (int k = 0; k < 3; k++) begin
      meas_here(p);
      chk(p == RECI, "R8 recovery length", p, RECI);
      if (usable || short_int) okc++;
    end
    chk(okc == 0, "R8 recovery results not usable", okc, 0);
    meas_here(p);
    chk(p == 60, "R8 normal length resumes", p, 60);
    chk(usable == 1'b1, "R8 usable after recovery", usable, 1);
  endtask

  task automatic t_div4();
    int p;
    do_reset();
    launch_run(50, 1'b1);
    int_len = 12'd10;
    meas_here(p);
    chk(p == 200, "R6 divide by four length", p, 200);
    chk(short_int == 1'b1, "R7 clamped under divide", short_int, 1);
    int_len = 12'd120;
    meas_here(p);
    chk(p == MINI * 4, "R7 clamped length under divide", p, MINI * 4);
    meas_here(p);
    chk(p == 480, "R8 recovery takes longer request", p, 480);
  endtask

  task automatic t_align();
    int bad;
    logic [4:0] v;
    do_reset();
    launch_run(40, 1'b0);
    bad = 0;
    for (int k = 0; k < 200; k++) begin
      step();
      v = {cvt, side_b, rd_win, usable, short_int};
      @(posedge clk);
      #1;
      if (v != {cvt, side_b, rd_win, usable, short_int}) bad++;
    end
    chk(bad == 0, "R10 outputs move only on falling edge", bad, 0);
  endtask

  task automatic t_midreset();
    int bad;
    do_reset();
    launch_run(60, 1'b0);
    repeat (20) step();
    rst_n = 1'b0;
    step();
    step();
    rst_n = 1'b1;
    bad = 0;
    for (int k = 0; k < 200; k++) begin
      step();
      if (cvt || side_b) bad++;
    end
    chk(bad == 0, "R9 idle after mid-run reset", bad, 0);
    launch_run(60, 1'b0);
    chk(cvt == 1'b1, "R9 restart after start", cvt, 1);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_warmup();
    t_window();
    t_short_recovery();
    t_div4();
    t_align();
    t_midreset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule